// File: doc/BRIEF.md
# Extended Control Register Bank with Test FIFO

This block is the upper register bank of a parallel port that can run in several transfer modes. Software selects the port's mode through an extended control register (ECR). The block reports the current FIFO state in the same register. It also provides a configuration byte and a small data FIFO. Software can load and drain that FIFO directly when the port is in FIFO-test mode. The current mode is driven out to the rest of the port logic. The FIFO empty and full flags are driven out as plain status pins.

Access uses a byte-wide register bus made of an offset, a write strobe, a read strobe, write data and read data. Every access takes one clock. Read data is registered. The bus carries no back-pressure: a write to a full FIFO and a read from an empty FIFO both complete at once, and the block resolves them internally as described below.

Top module: `ecpx_ctrl_bank`

## Requirements
- R1: After reset the mode is 0 (compatible), the ECR reads 0x01, `bus_rdata` is 0x00, the offset-0 data register and the offset-1 configuration byte read 0x00, and `fifo_empty_o`=1 and `fifo_full_o`=0.
- R2: A write to offset 2 loads the 3-bit mode from `bus_wdata[7:5]` and ignores `bus_wdata[4:0]`. The mode encoding is: 0 compatible, 1 bidirectional byte, 2 parallel-port FIFO, 3 ECP FIFO, 4 EPP, 5 reserved, 6 FIFO test, 7 configuration. `mode_o` shows the mode in the cycle after the write. A read of offset 2 returns {mode, 3'b000, status}.
- R3: The status field is bits 1:0 of the ECR: 2'b01 means empty, 2'b10 means full and 2'b00 means partly filled. `fifo_empty_o` and `fifo_full_o` carry the same two states.
- R4: In mode 6, a write to offset 0 pushes a byte into the FIFO (default depth 2) and a read of offset 0 pops one. Bytes leave in arrival order, and both pointers wrap around at the end of the storage.
- R5: A push to a full FIFO is dropped. The stored bytes and the flags stay unchanged.
- R6: A pop from an empty FIFO returns the most recently popped byte and leaves the flags unchanged.
- R7: An ECR write whose mode differs from the current mode empties the FIFO. An ECR write that keeps the same mode does not affect the FIFO.
- R8: In every mode except 6 and 7, offset 0 is a plain 8-bit read/write register. The FIFO does not touch this register.
- R9: In mode 7, a read of offset 0 returns the fixed byte 0x10, which is a width field in bits 6:4 with value 3'b001 (8-bit FIFO). Writes to offset 0 in this mode are ignored.
- R10: Offset 1 is an 8-bit read/write configuration byte.
- R11: Offsets 3 to 7 ignore writes and read as 0xFF.
- R12: `bus_rdata` takes the addressed value at the clock edge where `bus_rd_en` is high and holds it until the next read. When `bus_wr_en` and `bus_rd_en` are both high, only the write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one access per cycle |
| bus_rd_en | input | 1 | Read strobe, one access per cycle |
| bus_addr | input | ADDR_W | Register offset within the bank |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mode_o | output | 3 | Current port mode |
| fifo_empty_o | output | 1 | FIFO holds no bytes |
| fifo_full_o | output | 1 | FIFO holds DEPTH bytes |

## Verification
The bench builds the block with its defaults: DEPTH=2 and a 3-bit offset. At depth 2, three pushes are enough to reach the dropped-push case. One pop followed by a push is enough to wrap the write pointer back to entry 0, and two further pops prove that bytes still leave in order across the wrap. With a 3-bit offset, the bench can reach every unused offset, including the highest, 7.

// File: rtl/ecpx_pkg.sv
package ecpx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MODE_COMPAT  = 3'd0,
    MODE_BYTE    = 3'd1,
    MODE_PPFIFO  = 3'd2,
    MODE_ECPFIFO = 3'd3,
    MODE_EPP     = 3'd4,
    MODE_RSVD    = 3'd5,
    MODE_TEST    = 3'd6,
    MODE_CONFIG  = 3'd7
  } port_mode_e;

  localparam logic [1:0] FST_SOME  = 2'b00;
  localparam logic [1:0] FST_EMPTY = 2'b01;
  localparam logic [1:0] FST_FULL  = 2'b10;

  localparam int OFS_DATA = 0;
  localparam int OFS_CFGB = 1;
  localparam int OFS_ECR  = 2;

  localparam logic [2:0] WIDTH_CODE_8BIT = 3'b001;
  localparam logic [BYTE_W-1:0] CFGA_BYTE = {1'b0, WIDTH_CODE_8BIT, 4'b0000};
  localparam logic [BYTE_W-1:0] UNUSED_BYTE = '1;
endpackage

// File: rtl/ecpx_decode.sv
module ecpx_decode
  import ecpx_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  port_mode_e        mode,
  output logic              fifo_push,
  output logic              fifo_pop,
  output logic              plain_wr,
  output logic              cfgb_wr,
  output logic              ecr_wr,
  output logic              rd_fire
);
  logic at_data, at_cfgb, at_ecr;

  always_comb begin
    at_data   = (addr == ADDR_W'(OFS_DATA));
    at_cfgb   = (addr == ADDR_W'(OFS_CFGB));
    at_ecr    = (addr == ADDR_W'(OFS_ECR));
    rd_fire   = rd_en & ~wr_en;
    fifo_push = wr_en & at_data & (mode == MODE_TEST);
    fifo_pop  = rd_fire & at_data & (mode == MODE_TEST);
    plain_wr  = wr_en & at_data & (mode != MODE_TEST) & (mode != MODE_CONFIG);
    cfgb_wr   = wr_en & at_cfgb;
    ecr_wr    = wr_en & at_ecr;
  end

  p_single_action_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_push, fifo_pop, plain_wr, cfgb_wr, ecr_wr}))
    else $error("more than one bank action in a cycle");

  p_write_blocks_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !fifo_pop)
    else $error("pop taken during a write");
endmodule

// File: rtl/ecpx_mode_reg.sv
module ecpx_mode_reg
  import ecpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ecr_wr,
  input  logic [2:0] wmode,
  output port_mode_e mode_q,
  output logic       flush
);
  assign flush = ecr_wr && (wmode != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= MODE_COMPAT;
    else if (ecr_wr) mode_q <= port_mode_e'(wmode);
  end

  p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ecr_wr |=> mode_q == $past(wmode))
    else $error("mode not loaded");

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ecr_wr |=> $stable(mode_q))
    else $error("mode changed without a write");
endmodule

// File: rtl/ecpx_fifo.sv
module ecpx_fifo
  import ecpx_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full,
  output logic [1:0]        status
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] last_q;
  logic              push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CNT_FULL);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush & ~push;
  assign status  = empty ? FST_EMPTY : (full ? FST_FULL : FST_SOME);
  assign rdata   = empty ? last_q : mem[rptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                                  mem[i] <= '0;
      else if (push_ok && wptr == PTR_W'(i))       mem[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST_IDX) ? '0 : wptr + PTR_W'(1);
      if (pop_ok)  rptr <= (rptr == LAST_IDX) ? '0 : rptr + PTR_W'(1);
      if (push_ok)     count <= count + CNT_W'(1);
      else if (pop_ok) count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= '0;
    else if (pop_ok) last_q <= mem[rptr];
  end

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL)
    else $error("occupancy past depth");

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full))
    else $error("empty and full together");

  p_full_push_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !flush) |=> full && $stable(wptr))
    else $error("push into full FIFO took effect");

  p_empty_pop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> empty && $stable(last_q))
    else $error("pop from empty FIFO moved state");

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && rptr == '0 && wptr == '0)
    else $error("flush left data");
endmodule

// File: rtl/ecpx_regfile.sv
module ecpx_regfile
  import ecpx_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              plain_wr,
  input  logic              cfgb_wr,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  port_mode_e        mode,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic [1:0]        fifo_status,
  output logic [BYTE_W-1:0] rdata_q
);
  logic [BYTE_W-1:0] plain_q, cfgb_q, rd_mux, ecr_view;

  assign ecr_view = {mode, 3'b000, fifo_status};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plain_q <= '0;
      cfgb_q  <= '0;
    end else begin
      if (plain_wr) plain_q <= wdata;
      if (cfgb_wr)  cfgb_q  <= wdata;
    end
  end

  always_comb begin
    if (addr == ADDR_W'(OFS_DATA)) begin
      if (mode == MODE_TEST)        rd_mux = fifo_data;
      else if (mode == MODE_CONFIG) rd_mux = CFGA_BYTE;
      else                          rd_mux = plain_q;
    end else if (addr == ADDR_W'(OFS_CFGB)) begin
      rd_mux = cfgb_q;
    end else if (addr == ADDR_W'(OFS_ECR)) begin
      rd_mux = ecr_view;
    end else begin
      rd_mux = UNUSED_BYTE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_fire) rdata_q <= rd_mux;
  end

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rdata_q))
    else $error("read data changed without a read");

  p_plain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !plain_wr |=> $stable(plain_q))
    else $error("plain register changed without its write");
endmodule

// File: rtl/ecpx_ctrl_bank.sv
module ecpx_ctrl_bank
  import ecpx_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [2:0]        mode_o,
  output logic              fifo_empty_o,
  output logic              fifo_full_o
);
  port_mode_e        mode;
  logic              fifo_push, fifo_pop, plain_wr, cfgb_wr, ecr_wr, rd_fire;
  logic              flush;
  logic [BYTE_W-1:0] fifo_data;
  logic [1:0]        fifo_status;

  ecpx_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr), .mode(mode),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .plain_wr(plain_wr),
    .cfgb_wr(cfgb_wr), .ecr_wr(ecr_wr), .rd_fire(rd_fire)
  );

  ecpx_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .ecr_wr(ecr_wr), .wmode(bus_wdata[7:5]),
    .mode_q(mode), .flush(flush)
  );

  ecpx_fifo #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(fifo_push), .pop(fifo_pop),
    .wdata(bus_wdata), .rdata(fifo_data), .empty(fifo_empty_o),
    .full(fifo_full_o), .status(fifo_status)
  );

  ecpx_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .plain_wr(plain_wr), .cfgb_wr(cfgb_wr),
    .rd_fire(rd_fire), .addr(bus_addr), .wdata(bus_wdata), .mode(mode),
    .fifo_data(fifo_data), .fifo_status(fifo_status), .rdata_q(bus_rdata)
  );

  assign mode_o = mode;

  p_same_mode_keeps_fifo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ecr_wr && bus_wdata[7:5] == mode_o && !fifo_empty_o) |=> !fifo_empty_o)
    else $error("same-mode ECR write flushed FIFO");

  p_no_fifo_outside_test_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 3'd6 && !ecr_wr) |=> $stable(fifo_empty_o) && $stable(fifo_full_o))
    else $error("FIFO moved outside test mode");
endmodule

// File: tb/ecpx_ctrl_bank_bench.sv
`timescale 1ns/1ps
module ecpx_ctrl_bank_bench;
  localparam int NV = 44;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_RD = 2'd2;

  function automatic logic [16:0] mk(logic [1:0] op, logic [2:0] a, logic [7:0] d, logic [3:0] r);
    return {op, a, d, r};
  endfunction

  localparam logic [16:0] VEC [NV] = '{
    mk(OP_RD, 3'd2, 8'h01, 4'd1),   // R1 ECR reset value
    mk(OP_RD, 3'd0, 8'h00, 4'd1),   // R1 data register reset
    mk(OP_RD, 3'd1, 8'h00, 4'd1),   // R1 configuration byte reset
    mk(OP_WR, 3'd0, 8'hA5, 4'd8),   // R8 plain write
    mk(OP_RD, 3'd0, 8'hA5, 4'd8),   // R8
    mk(OP_WR, 3'd1, 8'h3C, 4'd10),  // R10
    mk(OP_RD, 3'd1, 8'h3C, 4'd10),  // R10
    mk(OP_WR, 3'd2, 8'hC0, 4'd2),   // R2 enter test mode
    mk(OP_RD, 3'd2, 8'hC1, 4'd2),   // R2
    mk(OP_WR, 3'd0, 8'h11, 4'd4),   // R4 push
    mk(OP_RD, 3'd2, 8'hC0, 4'd3),   // R3 partly filled
    mk(OP_WR, 3'd0, 8'h22, 4'd4),   // R4
    mk(OP_RD, 3'd2, 8'hC2, 4'd3),   // R3 full
    mk(OP_WR, 3'd0, 8'h33, 4'd5),   // R5 dropped push
    mk(OP_RD, 3'd2, 8'hC2, 4'd5),   // R5
    mk(OP_RD, 3'd0, 8'h11, 4'd4),   // R4 first out
    mk(OP_RD, 3'd2, 8'hC0, 4'd3),   // R3
    mk(OP_WR, 3'd0, 8'h44, 4'd4),   // R4 wrap of write pointer
    mk(OP_RD, 3'd2, 8'hC2, 4'd3),   // R3
    mk(OP_RD, 3'd0, 8'h22, 4'd4),   // R4
    mk(OP_RD, 3'd0, 8'h44, 4'd4),   // R4 after wrap
    mk(OP_RD, 3'd2, 8'hC1, 4'd3),   // R3 empty
    mk(OP_RD, 3'd0, 8'h44, 4'd6),   // R6 empty pop gives last byte
    mk(OP_RD, 3'd2, 8'hC1, 4'd6),   // R6
    mk(OP_WR, 3'd0, 8'h55, 4'd7),   // R7
    mk(OP_WR, 3'd2, 8'hDF, 4'd7),   // R7 same mode, low bits ignored (R2)
    mk(OP_RD, 3'd2, 8'hC0, 4'd7),   // R7 still holds a byte
    mk(OP_WR, 3'd2, 8'h20, 4'd7),   // R7 change to byte mode
    mk(OP_RD, 3'd2, 8'h21, 4'd7),   // R7 flushed
    mk(OP_RD, 3'd0, 8'hA5, 4'd8),   // R8 untouched by FIFO traffic
    mk(OP_WR, 3'd2, 8'hC0, 4'd7),   // R7
    mk(OP_RD, 3'd2, 8'hC1, 4'd7),   // R7 FIFO still empty
    mk(OP_WR, 3'd2, 8'hE0, 4'd9),   // R9 configuration mode
    mk(OP_RD, 3'd0, 8'h10, 4'd9),   // R9 width byte
    mk(OP_WR, 3'd0, 8'h77, 4'd9),   // R9 ignored write
    mk(OP_RD, 3'd2, 8'hE1, 4'd9),   // R9
    mk(OP_WR, 3'd2, 8'h00, 4'd9),   // R9
    mk(OP_RD, 3'd0, 8'hA5, 4'd9),   // R9 plain register kept
    mk(OP_WR, 3'd3, 8'h00, 4'd11),  // R11
    mk(OP_RD, 3'd3, 8'hFF, 4'd11),  // R11
    mk(OP_WR, 3'd7, 8'h12, 4'd11),  // R11
    mk(OP_RD, 3'd7, 8'hFF, 4'd11),  // R11
    mk(OP_RD, 3'd1, 8'h3C, 4'd11),  // R11 neighbours unchanged
    mk(OP_RD, 3'd2, 8'h01, 4'd11)   // R11
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] mode_o;
  logic       fifo_empty_o, fifo_full_o;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ecpx_ctrl_bank u_ecpx_ctrl_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode_o(mode_o), .fifo_empty_o(fifo_empty_o), .fifo_full_o(fifo_full_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode", {5'd0, mode_o}, 8'h00);
    check("R1 flags", {6'd0, fifo_full_o, fifo_empty_o}, 8'h01);
    check("R1 rdata", bus_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      if (v[16:15] == OP_WR) bus_write(v[14:12], v[11:4]);
      else begin
        bus_read(v[14:12], rd);
        check($sformatf("R%0d vector %0d", v[3:0], i), rd, v[11:4]);
      end
    end

    // R2: mode pin follows ECR write (EPP = 4)
    bus_write(3'd2, 8'h80);
    check("R2 mode pin", {5'd0, mode_o}, 8'h04);
    check("R3 empty pin", {7'd0, fifo_empty_o}, 8'h01);

    // R12: simultaneous write and read, write only
    bus_read(3'd2, rd);
    check("R12 pre", rd, 8'h81);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_rd_en = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h5A;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    check("R12 read suppressed", bus_rdata, 8'h81);
    bus_read(3'd1, rd);
    check("R10 write taken with read", rd, 8'h5A);
    repeat (3) @(negedge clk);
    check("R12 rdata held", bus_rdata, 8'h5A);

    // R3: full pin
    bus_write(3'd2, 8'hC0);
    bus_write(3'd0, 8'hAA);
    check("R3 partly filled pins", {6'd0, fifo_full_o, fifo_empty_o}, 8'h00);
    bus_write(3'd0, 8'hBB);
    check("R3 full pins", {6'd0, fifo_full_o, fifo_empty_o}, 8'h02);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode after reset", {5'd0, mode_o}, 8'h00);
    check("R1 flags after reset", {6'd0, fifo_full_o, fifo_empty_o}, 8'h01);
    check("R1 rdata after reset", bus_rdata, 8'h00);
    bus_read(3'd1, rd);
    check("R1 cfg byte after reset", rd, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule